// File: doc/BRIEF.md
# Scalar-to-Element Loop Issuer

This block sits between instruction decode and the issue stage. It takes one decoded scalar instruction (an opcode, a destination register and two source register numbers) together with a vector length, a looping-enable input and a per-operand mask. The mask marks which operands are vectors.

When looping is active, the block turns that single instruction into a run of internal micro-operations, one per element. The opcode is never altered. Operands marked as vectors advance their register number by one on each element. Operands left unmarked keep their number throughout. When looping is off, or the length is 0 or 1, the instruction passes through as a single operation.

Each element has its own carry bit and its own overflow/saturation flag. Both sets sit in two element-indexed registers. Software can read and write them whole, for example to save and restore them across a context switch. Result writeback from execution updates one element's bits at a time. Comparison results are steered to condition field 6 while looping.

Top module: `loop_issuer`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and both the carry register and the overflow register read as zero.
- R2: When `loop_en` is 0 or the effective length is 0 or 1, an accepted instruction produces exactly one operation. That operation has `out_idx` 0, `out_last` 1, the original register numbers and the original `in_crf`.
- R3: When looping is active, an accepted instruction produces as many operations as the effective length. They carry `out_idx` 0, 1, 2 and so on in order, with an unchanged opcode, and `out_last` is set only on the final one.
- R4: Mask bit 0 marks the destination as a vector, bit 1 the first source and bit 2 the second source. A marked operand reads base + `out_idx` modulo 2^REG_W, while an unmarked operand keeps its base number on every element.
- R5: `in_ready` is 0 from the cycle after an instruction is accepted until the final operation has been taken downstream, and it is 1 again in the following cycle.
- R6: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value into the next cycle.
- R7: `out_cin` equals bit `out_idx` of the carry register (bit i belongs to element i).
- R8: A `res_valid` pulse writes `res_cout` into carry bit `res_idx` and `res_ovf` into overflow bit `res_idx`. All other bits are left unchanged.
- R9: `csr_sel` 0 selects the carry register and 1 selects the overflow register. `csr_rdata` shows the selected register, and `csr_we` replaces it whole. A software write takes precedence over a writeback to the same register in the same cycle, while the other register still takes the writeback.
- R10: While looping is active, every operation carries `out_crf` = 6. Otherwise `out_crf` equals the incoming `in_crf`.
- R11: A vector length above MAXVL is treated as MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | 1 | Looping enabled for the incoming instruction |
| in_valid | input | 1 | Incoming instruction valid |
| in_ready | output | 1 | Block can accept an instruction |
| in_op | input | OP_W | Decoded opcode |
| in_rd | input | REG_W | Destination register number |
| in_ra | input | REG_W | First source register number |
| in_rb | input | REG_W | Second source register number |
| in_vec | input | 3 | Vector mask (bit0 rd, bit1 ra, bit2 rb) |
| in_vl | input | VL_W | Requested vector length |
| in_crf | input | 3 | Default condition field |
| out_valid | output | 1 | Micro-operation valid |
| out_ready | input | 1 | Issue stage takes the operation |
| out_op | output | OP_W | Opcode, unchanged |
| out_rd | output | REG_W | Element destination register |
| out_ra | output | REG_W | Element first source register |
| out_rb | output | REG_W | Element second source register |
| out_idx | output | IDX_W | Element index |
| out_last | output | 1 | Final element flag |
| out_cin | output | 1 | Carry-in bit for this element |
| out_crf | output | 3 | Condition field for a compare result |
| res_valid | input | 1 | Writeback of element flags |
| res_idx | input | IDX_W | Element written back |
| res_cout | input | 1 | Carry-out of that element |
| res_ovf | input | 1 | Overflow/saturation flag of that element |
| csr_we | input | 1 | Software write strobe |
| csr_sel | input | 1 | 0 carry register, 1 overflow register |
| csr_wdata | input | MAXVL | Software write data |
| csr_rdata | output | MAXVL | Selected register contents |

## Verification
The assertions assume that `in_valid` is raised only while `in_ready` is 1. They also assume that `res_idx` always names an element below MAXVL. The stimulus keeps to both conditions: it offers each instruction only after checking `in_ready`, and it returns flags only for element numbers 0 to MAXVL-1. Downstream stalls come from a fixed pattern that depends on the element number, so stall cycles land on first, middle and last elements across the sweep.

// File: rtl/loop_issuer.sv
module loop_issuer #(
  parameter int OP_W  = 8,
  parameter int REG_W = 5,
  parameter int MAXVL = 8,
  parameter int IDX_W = $clog2(MAXVL),
  parameter int VL_W  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [REG_W-1:0] in_rd,
  input  logic [REG_W-1:0] in_ra,
  input  logic [REG_W-1:0] in_rb,
  input  logic [2:0]       in_vec,
  input  logic [VL_W-1:0]  in_vl,
  input  logic [2:0]       in_crf,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OP_W-1:0]  out_op,
  output logic [REG_W-1:0] out_rd,
  output logic [REG_W-1:0] out_ra,
  output logic [REG_W-1:0] out_rb,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_last,
  output logic             out_cin,
  output logic [2:0]       out_crf,
  input  logic             res_valid,
  input  logic [IDX_W-1:0] res_idx,
  input  logic             res_cout,
  input  logic             res_ovf,
  input  logic             csr_we,
  input  logic             csr_sel,
  input  logic [MAXVL-1:0] csr_wdata,
  output logic [MAXVL-1:0] csr_rdata
);
  localparam logic [2:0] LOOP_CRF = 3'd6;

  logic             busy;
  logic             loop_q;
  logic [OP_W-1:0]  op_q;
  logic [REG_W-1:0] rd_q, ra_q, rb_q;
  logic [2:0]       vec_q, crf_q;
  logic [IDX_W-1:0] idx_q, lastidx_q;
  logic [MAXVL-1:0] carry_q, ovf_q;

  logic [VL_W-1:0]  vl_eff;
  logic             looping;
  logic [REG_W-1:0] step;

  assign vl_eff  = (int'(in_vl) > MAXVL) ? VL_W'(MAXVL) : in_vl;
  assign looping = loop_en && (vl_eff >= VL_W'(2));
  assign step    = REG_W'(idx_q);

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_op    = op_q;
  assign out_idx   = idx_q;
  assign out_last  = (idx_q == lastidx_q);
  assign out_rd    = rd_q + (vec_q[0] ? step : '0);
  assign out_ra    = ra_q + (vec_q[1] ? step : '0);
  assign out_rb    = rb_q + (vec_q[2] ? step : '0);
  assign out_cin   = carry_q[idx_q];
  assign out_crf   = loop_q ? LOOP_CRF : crf_q;
  assign csr_rdata = csr_sel ? ovf_q : carry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      loop_q    <= 1'b0;
      op_q      <= '0;
      rd_q      <= '0;
      ra_q      <= '0;
      rb_q      <= '0;
      vec_q     <= '0;
      crf_q     <= '0;
      idx_q     <= '0;
      lastidx_q <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        busy      <= 1'b1;
        loop_q    <= looping;
        op_q      <= in_op;
        rd_q      <= in_rd;
        ra_q      <= in_ra;
        rb_q      <= in_rb;
        vec_q     <= looping ? in_vec : 3'b000;
        crf_q     <= in_crf;
        idx_q     <= '0;
        lastidx_q <= looping ? IDX_W'(vl_eff - VL_W'(1)) : '0;
      end
    end else if (out_ready) begin
      if (out_last) busy <= 1'b0;
      else          idx_q <= idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= '0;
      ovf_q   <= '0;
    end else begin
      if (csr_we && !csr_sel)  carry_q <= csr_wdata;
      else if (res_valid)      carry_q[res_idx] <= res_cout;
      if (csr_we && csr_sel)   ovf_q <= csr_wdata;
      else if (res_valid)      ovf_q[res_idx] <= res_ovf;
    end
  end

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_idx == $past(out_idx) + IDX_W'(1) && out_op == $past(out_op));
  // R3
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_rd) && $stable(out_ra) && $stable(out_rb) && $stable(out_crf));
  // R4
  scalar_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last && !vec_q[1] |=> out_ra == $past(out_ra));
  // R10
  loop_crf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_idx != '0 |-> out_crf == LOOP_CRF);
  // R8
  carry_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !csr_we |=> carry_q[$past(res_idx)] == $past(res_cout) && ovf_q[$past(res_idx)] == $past(res_ovf));
  // R9
  csr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && !csr_sel |=> carry_q == $past(csr_wdata));
endmodule

// File: tb/test_loop_issuer.sv
module test_loop_issuer;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W = 8, REG_W = 5, MAXVL = 8, IDX_W = 3, VL_W = 4;

  logic clk = 0, rst_n = 0;
  logic loop_en = 0, in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [OP_W-1:0] in_op = 0, out_op;
  logic [REG_W-1:0] in_rd = 0, in_ra = 0, in_rb = 0, out_rd, out_ra, out_rb;
  logic [2:0] in_vec = 0, in_crf = 0, out_crf;
  logic [VL_W-1:0] in_vl = 0;
  logic [IDX_W-1:0] out_idx, res_idx = 0;
  logic out_last, out_cin, res_valid = 0, res_cout = 0, res_ovf = 0;
  logic csr_we = 0, csr_sel = 0;
  logic [MAXVL-1:0] csr_wdata = 0, csr_rdata;
  logic [MAXVL-1:0] carry_m;

  int errors = 0, checks = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_issuer #(.OP_W(OP_W), .REG_W(REG_W), .MAXVL(MAXVL)) i_loop_issuer (
    .clk, .rst_n, .loop_en, .in_valid, .in_ready, .in_op, .in_rd, .in_ra, .in_rb,
    .in_vec, .in_vl, .in_crf, .out_valid, .out_ready, .out_op, .out_rd, .out_ra,
    .out_rb, .out_idx, .out_last, .out_cin, .out_crf, .res_valid, .res_idx,
    .res_cout, .res_ovf, .csr_we, .csr_sel, .csr_wdata, .csr_rdata);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input bit le, input int vl, input int vec, input int op, input int rd,
                     input int ra, input int rb, input int crf);
    int n;
    bit lp;
    int veff;
    veff = (vl > MAXVL) ? MAXVL : vl;
    lp = le && veff >= 2;
    n = lp ? veff : 1;
    @(negedge clk);
    chk(in_ready == 1, "R5", "ready before", in_ready, 1);
    in_valid = 1; loop_en = le; in_vl = VL_W'(vl); in_vec = 3'(vec);
    in_op = 8'(op); in_rd = 5'(rd); in_ra = 5'(ra); in_rb = 5'(rb); in_crf = 3'(crf);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    for (int k = 0; k < n; k++) begin
      int erd, era, erb;
      erd = (rd + ((lp && vec[0]) ? k : 0)) % 32;
      era = (ra + ((lp && vec[1]) ? k : 0)) % 32;
      erb = (rb + ((lp && vec[2]) ? k : 0)) % 32;
      if ((k + vl) % 3 == 0) begin
        out_ready = 0;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1 && out_idx == 3'(k), "R6", "stall idx", out_idx, k);
        chk(out_rd == 5'(erd), "R6", "stall rd", out_rd, erd);
      end
      out_ready = 1;
      chk(out_valid == 1, "R3", "valid", out_valid, 1);
      chk(in_ready == 0, "R5", "ready busy", in_ready, 0);
      chk(out_idx == 3'(k), lp ? "R3" : "R2", "idx", out_idx, k);
      chk(out_last == (k == n-1), lp ? "R3" : "R2", "last", out_last, k == n-1);
      chk(out_op == 8'(op), "R3", "op", out_op, op);
      chk(out_rd == 5'(erd), "R4", "rd", out_rd, erd);
      chk(out_ra == 5'(era), "R4", "ra", out_ra, era);
      chk(out_rb == 5'(erb), "R4", "rb", out_rb, erb);
      chk(out_crf == (lp ? 3'd6 : 3'(crf)), "R10", "crf", out_crf, lp ? 6 : crf);
      chk(out_cin == carry_m[k], "R7", "cin", out_cin, carry_m[k]);
      if (vl > MAXVL && le) chk(n == MAXVL, "R11", "clamp", n, MAXVL);
      @(posedge clk);
      @(negedge clk);
    end
    out_ready = 0;
    chk(out_valid == 0, "R3", "done valid", out_valid, 0);
    chk(in_ready == 1, "R5", "ready after", in_ready, 1);
  endtask

  task automatic csr_write(input bit sel, input logic [MAXVL-1:0] d);
    @(negedge clk);
    csr_we = 1; csr_sel = sel; csr_wdata = d;
    @(posedge clk);
    @(negedge clk);
    csr_we = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1, "R1", "ready", in_ready, 1);
    chk(out_valid == 0, "R1", "valid", out_valid, 0);
    csr_sel = 0; #1;
    chk(csr_rdata == 0, "R1", "carry", csr_rdata, 0);
    csr_sel = 1; #1;
    chk(csr_rdata == 0, "R1", "ovf", csr_rdata, 0);
    rst_n = 1;

    carry_m = 8'hA5;
    csr_write(0, carry_m);
    csr_sel = 0; #1;
    chk(csr_rdata == carry_m, "R9", "carry write", csr_rdata, carry_m);

    for (int le = 0; le < 2; le++)
      for (int vl = 0; vl < 16; vl++)
        for (int vec = 0; vec < 8; vec++)
          run(bit'(le), vl, vec, 16*vl + vec, (27 + 5*vec + vl) % 32,
              (3*vl + 29) % 32, (vec + 30) % 32, vl % 6);

    carry_m = 8'h3C;
    csr_write(0, carry_m);
    run(1, 8, 7, 9, 31, 0, 25, 2);

    @(negedge clk);
    res_valid = 1; res_idx = 3'd2; res_cout = 0; res_ovf = 1;
    @(posedge clk); @(negedge clk);
    res_idx = 3'd7; res_cout = 1; res_ovf = 1;
    @(posedge clk); @(negedge clk);
    res_valid = 0;
    carry_m = 8'hB8;
    csr_sel = 0; #1;
    chk(csr_rdata == 8'hB8, "R8", "carry wb", csr_rdata, 8'hB8);
    csr_sel = 1; #1;
    chk(csr_rdata == 8'h84, "R8", "ovf wb", csr_rdata, 8'h84);

    @(negedge clk);
    csr_we = 1; csr_sel = 0; csr_wdata = 8'h0F;
    res_valid = 1; res_idx = 3'd6; res_cout = 1; res_ovf = 1;
    @(posedge clk); @(negedge clk);
    csr_we = 0; res_valid = 0;
    csr_sel = 0; #1;
    chk(csr_rdata == 8'h0F, "R9", "sw wins carry", csr_rdata, 8'h0F);
    csr_sel = 1; #1;
    chk(csr_rdata == 8'hC4, "R9", "ovf still wb", csr_rdata, 8'hC4);
    csr_write(1, 8'h11);
    csr_sel = 1; #1;
    chk(csr_rdata == 8'h11, "R9", "ovf write", csr_rdata, 8'h11);
    csr_sel = 0; #1;
    chk(csr_rdata == 8'h0F, "R9", "carry untouched", csr_rdata, 8'h0F);
    carry_m = 8'h0F;
    run(1, 5, 5, 3, 4, 6, 8, 1);

    summary();
    $finish;
  end
endmodule